// File: doc/BRIEF.md
# Write-Protect and Status Register Controller

This block owns the status byte of a small serial nonvolatile memory and decides whether each requested nonvolatile write may go ahead. A command decoder in front of it presents one-cycle strobes: set the write-enable latch, clear it, write the status byte, or write the array at a given address. The block checks each request against two protection layers. The first layer covers status writes. It combines the enable latch with a matrix formed by the status-guard bit and an active-low lock pin. The second layer covers array writes. It uses the enable latch and a 2-bit fence code that marks nothing, the top quarter, the top half or the whole array as read-only.

A granted write starts a self-timed programming cycle. In this block that cycle is a counter of `PROG_CYCLES` system clocks. While it runs, the in-progress bit reads 1 and the status byte stays readable. Every command arriving in that window is dropped. When the cycle ends, the in-progress bit and the enable latch both fall. A granted status write takes effect on its writable fields at that same moment. Each decision is reported as a one-cycle grant or deny pulse.

Top module: `wpsc_ctrl`

## Requirements
- R1: After synchronous reset, `status_q` is 0x00, `busy` is 0 and all four grant and deny outputs are 0.
- R2: A set-enable strobe makes `status_q[1]` (enable latch) 1 and a clear-enable strobe makes it 0, one clock later. This holds for every guard-bit, fence and lock-pin state.
- R3: A status write made while the enable latch is 0 gives `sts_deny` and leaves `status_q` unchanged, with no cycle started.
- R4: A status write made while the enable latch is 1, `status_q[7]` (guard bit) is 1 and `lock_pin_n` is 0 gives `sts_deny` and leaves the enable latch at 1. With the latch at 1 and either the guard bit at 0 or the pin at 1, the write is granted.
- R5: A granted status write loads bit 7 (guard) and bits 3:2 (fence code) from `sts_wdata` at the end of the cycle. Bits 6:4 always read 0. Bits 1:0 of the written byte have no effect.
- R6: An array write is denied when its address lies in the fenced region. Fence code 00 fences nothing, 01 fences addresses 0x600 and above, 10 fences 0x400 and above, and 11 fences every address. A denied array write starts no cycle and leaves the enable latch unchanged.
- R7: An array write to an unfenced address is granted when the enable latch is 1 and denied when it is 0. The guard bit and the lock pin have no effect on it.
- R8: After a grant, `busy` and `status_q[0]` are 1 for exactly `PROG_CYCLES` clocks. After that, both `status_q[0]` and `status_q[1]` are 0.
- R9: While `busy` is 1, every strobe is ignored: no grant or deny pulse appears, the enable latch does not change, and `status_q` stays readable.
- R10: A change on `lock_pin_n` after a status write has been granted does not stop that write from taking effect.
- R11: When several strobes arrive in the same cycle, only one acts, in this priority order: clear-enable, then set-enable, then status write, then array write. The others leave no trace.
- R12: Each grant or deny output is a single-cycle pulse, one clock after its strobe. At most one of the four is 1 in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wel_set | input | 1 | Set-enable-latch strobe |
| wel_clr | input | 1 | Clear-enable-latch strobe |
| sts_wr | input | 1 | Status write strobe |
| sts_wdata | input | 8 | Byte offered with a status write |
| arr_wr | input | 1 | Array write strobe |
| arr_addr | input | ADDR_W | Target address of an array write |
| lock_pin_n | input | 1 | Active-low write-lock pin for the status byte |
| status_q | output | 8 | Status byte for readback |
| sts_grant | output | 1 | Status write accepted pulse |
| sts_deny | output | 1 | Status write refused pulse |
| arr_grant | output | 1 | Array write accepted pulse |
| arr_deny | output | 1 | Array write refused pulse |
| busy | output | 1 | Programming cycle running |

## Verification
Some rules are checked on every cycle by the assertions:
- a grant needs the enable latch to have been 1;
- no decision appears while a cycle runs;
- a status grant never coincides with an active lock;
- the pulses are mutually exclusive;
- the fence code holds steady across a running cycle;
- the enable latch is low when `busy` falls.

Other behaviours only the bench scenarios can show. These are the exact cycle length, the field mask applied at commit, the fence boundaries at each of their edge addresses, the priority among simultaneous strobes, and the fact that a status write committed after the lock pin dropped mid-cycle. The bench sweeps every lock combination and every fence code over a grid of addresses plus the boundary addresses.

// File: rtl/wpsc_pkg.sv
package wpsc_pkg;

    localparam int STS_W = 8;
    // Bits of the status byte kept in the nonvolatile store: guard (7), fence (3:2)
    localparam logic [STS_W-1:0] NV_MASK = 8'h8C;

    typedef enum logic [2:0] {
        OP_NONE    = 3'd0,
        OP_WEL_CLR = 3'd1,
        OP_WEL_SET = 3'd2,
        OP_STS_WR  = 3'd3,
        OP_ARR_WR  = 3'd4
    } op_e;

    typedef struct packed {
        logic       guard_en;
        logic [2:0] rsvd;
        logic [1:0] fence;
        logic       wel;
        logic       wip;
    } status_t;

    typedef struct packed {
        logic grant;
        logic deny;
    } verdict_t;

    // Lowest fenced address for a fence code; depth returned means nothing fenced
    function automatic int unsigned fence_floor(input logic [1:0] code,
                                                input int unsigned depth);
        case (code)
            2'b00:   return depth;
            2'b01:   return depth - depth / 4;
            2'b10:   return depth / 2;
            default: return 0;
        endcase
    endfunction

endpackage

// File: rtl/wpsc_cmd_sel.sv
module wpsc_cmd_sel
    import wpsc_pkg::*;
(
    input  logic wel_set,
    input  logic wel_clr,
    input  logic sts_wr,
    input  logic arr_wr,
    input  logic busy,
    output op_e  op
);

    // Fixed priority; everything dropped while a programming cycle runs (R9, R11)
    always_comb begin
        op = OP_NONE;
        if (!busy) begin
            if (wel_clr)      op = OP_WEL_CLR;
            else if (wel_set) op = OP_WEL_SET;
            else if (sts_wr)  op = OP_STS_WR;
            else if (arr_wr)  op = OP_ARR_WR;
        end
    end

endmodule

// File: rtl/wpsc_guard.sv
module wpsc_guard
    import wpsc_pkg::*;
#(
    parameter int ADDR_W = 11
) (
    input  op_e               op,
    input  logic              wel,
    input  logic              guard_en,
    input  logic [1:0]        fence,
    input  logic              lock_pin_n,
    input  logic [ADDR_W-1:0] addr,
    output verdict_t          sts_v,
    output verdict_t          arr_v
);

    localparam int unsigned DEPTH = 1 << ADDR_W;

    logic sts_locked;
    logic addr_fenced;
    logic [ADDR_W:0] floor_addr;

    assign floor_addr  = (ADDR_W + 1)'(fence_floor(fence, DEPTH));
    assign sts_locked  = guard_en && !lock_pin_n;
    assign addr_fenced = {1'b0, addr} >= floor_addr;

    always_comb begin
        sts_v = '0;
        arr_v = '0;
        if (op == OP_STS_WR) begin
            sts_v.grant = wel && !sts_locked;
            sts_v.deny  = !(wel && !sts_locked);
        end
        if (op == OP_ARR_WR) begin
            arr_v.grant = wel && !addr_fenced;
            arr_v.deny  = !(wel && !addr_fenced);
        end
    end

endmodule

// File: rtl/wpsc_timer.sv
module wpsc_timer #(
    parameter int CYCLES = 5000
) (
    input  logic clk,
    input  logic rst,
    input  logic start,
    output logic busy,
    output logic done
);

    localparam int CW = (CYCLES > 1) ? $clog2(CYCLES) : 1;
    localparam logic [CW-1:0] LAST = CW'(CYCLES - 1);

    logic [CW-1:0] cnt;

    assign done = busy && (cnt == LAST);

    always_ff @(posedge clk) begin
        if (rst) begin
            busy <= 1'b0;
            cnt  <= '0;
        end else if (start) begin
            busy <= 1'b1;
            cnt  <= '0;
        end else if (done) begin
            busy <= 1'b0;
            cnt  <= '0;
        end else if (busy) begin
            cnt <= cnt + 1'b1;
        end
    end

    p_cnt_bound_r8: assert property (@(posedge clk) disable iff (rst)
        busy |-> (cnt <= LAST));

    p_start_when_idle_r9: assert property (@(posedge clk) disable iff (rst)
        start |-> !busy);

endmodule

// File: rtl/wpsc_ctrl.sv
module wpsc_ctrl
    import wpsc_pkg::*;
#(
    parameter int ADDR_W      = 11,
    parameter int PROG_CYCLES = 5000
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wel_set,
    input  logic              wel_clr,
    input  logic              sts_wr,
    input  logic [7:0]        sts_wdata,
    input  logic              arr_wr,
    input  logic [ADDR_W-1:0] arr_addr,
    input  logic              lock_pin_n,
    output logic [7:0]        status_q,
    output logic              sts_grant,
    output logic              sts_deny,
    output logic              arr_grant,
    output logic              arr_deny,
    output logic              busy
);

    op_e        op;
    verdict_t   sts_v;
    verdict_t   arr_v;
    status_t    cur;
    logic       done;
    logic       start;
    logic       wel_q;
    logic       pend_vld;
    logic [7:0] nv_q;
    logic [7:0] pend_q;

    assign status_q = nv_q | {6'b0, wel_q, busy};
    assign cur      = status_t'(status_q);
    assign start    = sts_v.grant || arr_v.grant;

    wpsc_cmd_sel u_sel (
        .wel_set (wel_set),
        .wel_clr (wel_clr),
        .sts_wr  (sts_wr),
        .arr_wr  (arr_wr),
        .busy    (busy),
        .op      (op)
    );

    wpsc_guard #(.ADDR_W(ADDR_W)) u_guard (
        .op         (op),
        .wel        (cur.wel),
        .guard_en   (cur.guard_en),
        .fence      (cur.fence),
        .lock_pin_n (lock_pin_n),
        .addr       (arr_addr),
        .sts_v      (sts_v),
        .arr_v      (arr_v)
    );

    wpsc_timer #(.CYCLES(PROG_CYCLES)) u_timer (
        .clk   (clk),
        .rst   (rst),
        .start (start),
        .busy  (busy),
        .done  (done)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            wel_q     <= 1'b0;
            nv_q      <= '0;
            pend_q    <= '0;
            pend_vld  <= 1'b0;
            sts_grant <= 1'b0;
            sts_deny  <= 1'b0;
            arr_grant <= 1'b0;
            arr_deny  <= 1'b0;
        end else begin
            sts_grant <= sts_v.grant;
            sts_deny  <= sts_v.deny;
            arr_grant <= arr_v.grant;
            arr_deny  <= arr_v.deny;
            case (op)
                OP_WEL_CLR: wel_q <= 1'b0;
                OP_WEL_SET: wel_q <= 1'b1;
                OP_STS_WR: if (sts_v.grant) begin
                    pend_q   <= sts_wdata & NV_MASK;
                    pend_vld <= 1'b1;
                end
                default: ;
            endcase
            if (done) begin
                wel_q    <= 1'b0;
                pend_vld <= 1'b0;
                if (pend_vld) nv_q <= pend_q;
            end
        end
    end

    p_grant_needs_wel_r3: assert property (@(posedge clk) disable iff (rst)
        (sts_grant || arr_grant) |-> $past(wel_q));

    p_lock_blocks_status_r4: assert property (@(posedge clk) disable iff (rst)
        sts_grant |-> !($past(nv_q[7]) && !$past(lock_pin_n)));

    p_end_clears_wel_r8: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> !wel_q);

    p_quiet_while_busy_r9: assert property (@(posedge clk) disable iff (rst)
        (sts_grant || sts_deny || arr_grant || arr_deny) |-> !$past(busy));

    p_fence_hold_r10: assert property (@(posedge clk) disable iff (rst)
        (busy && $past(busy)) |-> $stable(nv_q));

    p_one_verdict_r12: assert property (@(posedge clk) disable iff (rst)
        $onehot0({sts_grant, sts_deny, arr_grant, arr_deny}));

endmodule

// File: tb/wpsc_ctrl_test.sv
module wpsc_ctrl_test;

    localparam int AW = 11;
    localparam int P  = 4;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          wel_set = 0, wel_clr = 0, sts_wr = 0, arr_wr = 0;
    logic [7:0]    sts_wdata = '0;
    logic [AW-1:0] arr_addr = '0;
    logic          lock_pin_n = 1'b1;
    logic [7:0]    status_q;
    logic          sts_grant, sts_deny, arr_grant, arr_deny, busy;

    int n_run  = 0;
    int n_fail = 0;
    bit finished = 0;

    always #4 clk = ~clk;

    wpsc_ctrl #(.ADDR_W(AW), .PROG_CYCLES(P)) uut (
        .clk(clk), .rst(rst), .wel_set(wel_set), .wel_clr(wel_clr),
        .sts_wr(sts_wr), .sts_wdata(sts_wdata), .arr_wr(arr_wr),
        .arr_addr(arr_addr), .lock_pin_n(lock_pin_n), .status_q(status_q),
        .sts_grant(sts_grant), .sts_deny(sts_deny), .arr_grant(arr_grant),
        .arr_deny(arr_deny), .busy(busy)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // Called at a falling edge; returns at the falling edge after the strobe edge
    task automatic drive(input logic s, input logic c, input logic sw, input logic aw,
                         input logic [7:0] d, input logic [AW-1:0] a);
        wel_set = s; wel_clr = c; sts_wr = sw; arr_wr = aw;
        sts_wdata = d; arr_addr = a;
        @(posedge clk);
        @(negedge clk);
        wel_set = 0; wel_clr = 0; sts_wr = 0; arr_wr = 0;
    endtask

    task automatic wait_cycle(input string req);
        for (int i = 0; i < P; i++) begin
            check(req, {busy, status_q[0]}, 2'b11);
            @(negedge clk);
        end
        check(req, {busy, status_q[1:0]}, 3'b000);
    endtask

    task automatic put_status(input logic [7:0] v);
        lock_pin_n = 1'b1;
        drive(1, 0, 0, 0, 8'h00, '0);
        drive(0, 0, 1, 0, v, '0);
        check("R4 setup grant", sts_grant, 1'b1);
        wait_cycle("R8 setup cycle");
        check("R5 commit", status_q, {v[7], 3'b000, v[3:2], 2'b00});
    endtask

    task automatic arr_try(input logic [1:0] bp, input int a);
        bit prot;
        prot = (bp == 2'd3) || (bp == 2'd2 && a >= 'h400) || (bp == 2'd1 && a >= 'h600);
        drive(1, 0, 0, 0, 8'h00, '0);
        drive(0, 0, 0, 1, 8'h00, AW'(a));
        if (prot) begin
            check("R6 fenced deny", {arr_grant, arr_deny}, 2'b01);
            @(negedge clk);
            check("R12 pulse width", {arr_grant, arr_deny}, 2'b00);
            check("R6 latch kept, no cycle", {busy, status_q[1]}, 2'b01);
            drive(0, 1, 0, 0, 8'h00, '0);
        end else begin
            check("R7 open grant", {arr_grant, arr_deny}, 2'b10);
            wait_cycle("R8 array cycle");
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1
        check("R1 reset status", status_q, 8'h00);
        check("R1 reset flags", {busy, sts_grant, sts_deny, arr_grant, arr_deny}, 5'b0);

        // R2 plain
        drive(1, 0, 0, 0, 8'h00, '0);
        check("R2 set", status_q, 8'h02);
        drive(0, 1, 0, 0, 8'h00, '0);
        check("R2 clear", status_q, 8'h00);

        // R3: latch off
        drive(0, 0, 1, 0, 8'h8C, '0);
        check("R3 deny", {sts_grant, sts_deny}, 2'b01);
        check("R3 unchanged", {busy, status_q}, 9'h000);

        // R4 matrix: guard bit x lock pin
        for (int g = 0; g < 2; g++) begin
            for (int pin = 0; pin < 2; pin++) begin
                put_status({g[0], 7'h00});
                lock_pin_n = pin[0];
                drive(1, 0, 0, 0, 8'h00, '0);
                check("R2 set under lock", status_q[1], 1'b1);
                drive(0, 0, 1, 0, {g[0], 7'h0C}, '0);
                if (g == 1 && pin == 0) begin
                    check("R4 locked deny", {sts_grant, sts_deny}, 2'b01);
                    check("R4 latch kept", {busy, status_q}, {1'b0, 8'h82});
                    drive(0, 1, 0, 0, 8'h00, '0);
                    check("R2 clear under lock", status_q, 8'h80);
                end else begin
                    check("R4 open grant", {sts_grant, sts_deny}, 2'b10);
                    wait_cycle("R8 status cycle");
                    check("R4 commit", status_q, {g[0], 7'h0C});
                end
            end
        end

        // R5: mask
        put_status(8'hFF);
        check("R5 masked", status_q, 8'h8C);
        put_status(8'h73);
        check("R5 masked low", status_q, 8'h00);

        // R7: latch off denies array
        drive(0, 0, 0, 1, 8'h00, '0);
        check("R7 latch off deny", {arr_grant, arr_deny, busy}, 3'b010);

        // R6/R7 sweep, with lock active to show it has no effect on the array
        for (int bp = 0; bp < 4; bp++) begin
            put_status({1'b1, 3'b000, bp[1:0], 2'b00});
            lock_pin_n = 1'b0;
            for (int a = 0; a < 2048; a += 128) arr_try(bp[1:0], a);
            arr_try(bp[1:0], 'h3FF);
            arr_try(bp[1:0], 'h400);
            arr_try(bp[1:0], 'h5FF);
            arr_try(bp[1:0], 'h600);
            arr_try(bp[1:0], 'h7FF);
        end

        // R9: commands during a cycle
        put_status(8'h00);
        drive(1, 0, 0, 0, 8'h00, '0);
        drive(0, 0, 0, 1, 8'h00, '0);
        check("R9 start", arr_grant, 1'b1);
        drive(0, 1, 0, 0, 8'h00, '0);
        check("R9 clear ignored", {sts_grant, sts_deny, arr_grant, arr_deny, status_q}, {4'b0, 8'h03});
        drive(0, 0, 1, 0, 8'h0C, '0);
        check("R9 status ignored", {sts_grant, sts_deny, status_q}, {2'b0, 8'h03});
        drive(0, 0, 0, 1, 8'h00, '0);
        check("R9 array ignored", {arr_grant, arr_deny, busy}, 3'b001);
        @(negedge clk);
        check("R9 end", {busy, status_q}, 9'h000);

        // R10: pin drops after grant
        put_status(8'h80);
        lock_pin_n = 1'b1;
        drive(1, 0, 0, 0, 8'h00, '0);
        drive(0, 0, 1, 0, 8'h84, '0);
        check("R10 grant", sts_grant, 1'b1);
        lock_pin_n = 1'b0;
        wait_cycle("R10 cycle");
        check("R10 committed", status_q, 8'h84);

        // R11: priority
        lock_pin_n = 1'b1;
        drive(1, 1, 0, 0, 8'h00, '0);
        check("R11 clear beats set", status_q[1], 1'b0);
        drive(1, 0, 1, 0, 8'h0C, '0);
        check("R11 set beats status", {sts_grant, sts_deny, status_q[1]}, 3'b001);
        drive(0, 0, 1, 1, 8'h08, '0);
        check("R11 status beats array", {sts_grant, arr_grant, arr_deny}, 3'b100);
        wait_cycle("R11 cycle");
        check("R11 commit", status_q, 8'h08);

        finished = 1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule